// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Encoder

This block turns a nibble-wide frame stream into the three-level line signal of a 100 Mbps twisted-pair link. It runs on one 125 MHz clock. An internal divide-by-five phase counter sets the nibble rate, and the input accepts one nibble on each of those slots. Each frame is wrapped in delimiter code-groups. The first byte of the frame (its first two nibbles) is replaced by the start pair J,K. Every later nibble is mapped to its 5-bit data code-group. A T,R end pair is appended after the frame. Idle code-groups fill all time between frames.

The code-group stream leaves the block most significant bit first, one bit per clock. Each bit is XORed with an 11-bit additive scrambler sequence. The result drives a three-level coder whose output is a 2-bit level code. The block does not parse frame fields. Preamble, start-of-frame delimiter, payload and CRC nibbles are all handled the same way, apart from the start-pair substitution.

The input is a valid/ready stream. `in_ready` is high for one cycle on a nibble slot. A nibble is taken on a rising edge where `in_valid` and `in_ready` are both high, and the source must hold `in_data` until then. A slot where `in_ready` is high and `in_valid` is low ends the current frame. The slot after that end decision carries R, and `in_ready` stays low during it. This is the only back-pressure the block applies. A source that keeps `in_valid` high there simply waits one more slot.

Top module: `fe_tx_encoder`

## Requirements
- R1: `in_ready` is high for exactly one cycle in every five, starting at the fifth cycle after reset. The only exception is the R slot (see R6). A nibble is consumed on an edge where `in_valid` and `in_ready` are both high.
- R2: While no frame is in progress, the code-group sent in every slot is idle, 5'b11111.
- R3: The first two nibbles accepted after an idle period are not encoded. Whatever their values, they are sent as J (5'b11000) followed by K (5'b10001).
- R4: Every later nibble of the frame is sent as its data code-group: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R5: A frame ends at the first nibble slot where `in_valid` is low. That slot sends T (5'b01101), the next slot sends R (5'b00111), and idle follows. A frame of only two nibbles therefore becomes J,K,T,R.
- R6: During the R slot, `in_ready` stays low and no nibble is taken. When `in_valid` stays high across it, the next ready slot comes ten cycles after the end-deciding slot, and that nibble starts a new frame with J.
- R7: Code-group bits are sent MSB first, one per clock. Each bit is XORed with key = s[10] XOR s[8] of an 11-bit register s. Every clock, s shifts left and takes the key in at bit 0 (x^11 + x^9 + 1). s is 11'h7FF after reset.
- R8: The level code is 2'b11 for negative, 2'b00 for zero and 2'b01 for positive, and 2'b10 never appears. A scrambled bit of 0 holds the level. A bit of 1 steps it through the cycle negative, zero, positive, zero.
- R9: During reset the level is zero and `in_ready` is low. The first step after reset goes to positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Transmit-enable: a frame nibble is offered |
| in_data | input | 4 | Frame nibble |
| in_ready | output | 1 | Nibble slot open; transfer when both valid and ready |
| line_lvl | output | 2 | Three-level line code: 11 negative, 00 zero, 01 positive |

## Verification
Two things can fall on the same nibble slot: the end of one frame and the start request of the next. The bench provokes this by raising `in_valid` with the next frame's first nibble right after the slot that ended the previous frame. `in_valid` is then still high during the R slot. The bench measures the ten-cycle ready gap, and checks that the decoded stream shows T,R immediately followed by a complete J,K-led frame with nothing lost. The line output is judged by decoding level changes back into bits and descrambling them with an independent sequence. Each step is compared against the expected position in the level cycle.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_KSYM = 2'd1,
    FS_BODY = 2'd2,
    FS_TAIL = 2'd3
  } fstate_t;

  localparam logic [4:0] CG_IDLE  = 5'b11111;
  localparam logic [4:0] CG_START = 5'b11000;
  localparam logic [4:0] CG_PAIR  = 5'b10001;
  localparam logic [4:0] CG_TERM  = 5'b01101;
  localparam logic [4:0] CG_RESET = 5'b00111;

  localparam logic [1:0] LV_NEG  = 2'b11;
  localparam logic [1:0] LV_ZERO = 2'b00;
  localparam logic [1:0] LV_POS  = 2'b01;

  function automatic logic [4:0] nib_to_cg(input logic [3:0] n);
    logic [4:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/fe_tx_framer.sv
module fe_tx_framer
  import fe_tx_pkg::*;
#(
  parameter int DIV   = 5,
  parameter int NIB_W = 4,
  parameter int CG_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NIB_W-1:0] in_data,
  output logic             in_ready,
  output logic             slot,
  output logic [CG_W-1:0]  cg
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase;
  fstate_t         st, st_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (phase == PH_LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign slot     = (phase == PH_LAST);
  assign in_ready = slot && (st != FS_TAIL);

  always_comb begin
    st_nx = st;
    cg    = CG_IDLE;
    unique case (st)
      FS_IDLE: begin
        if (in_valid) begin
          cg    = CG_START;
          st_nx = FS_KSYM;
        end
      end
      FS_KSYM: begin
        if (in_valid) begin
          cg    = CG_PAIR;
          st_nx = FS_BODY;
        end else begin
          cg    = CG_TERM;
          st_nx = FS_TAIL;
        end
      end
      FS_BODY: begin
        if (in_valid) begin
          cg = nib_to_cg(in_data);
        end else begin
          cg    = CG_TERM;
          st_nx = FS_TAIL;
        end
      end
      default: begin
        cg    = CG_RESET;
        st_nx = FS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= FS_IDLE;
    end else if (slot) begin
      st <= st_nx;
    end
  end
endmodule

// File: rtl/fe_tx_scrambler.sv
module fe_tx_scrambler #(
  parameter int          CG_W   = 5,
  parameter int          LFSR_W = 11,
  parameter int          TAP    = 8,
  parameter logic [10:0] SEED   = 11'h7FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CG_W-1:0] cg,
  output logic            scr_bit
);
  logic [CG_W-1:0]   sh;
  logic [LFSR_W-1:0] lfsr;
  logic              key;

  assign key     = lfsr[LFSR_W-1] ^ lfsr[TAP];
  assign scr_bit = sh[CG_W-1] ^ key;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '1;
      lfsr <= LFSR_W'(SEED);
    end else begin
      lfsr <= {lfsr[LFSR_W-2:0], key};
      if (load) begin
        sh <= cg;
      end else begin
        sh <= {sh[CG_W-2:0], 1'b1};
      end
    end
  end
endmodule

// File: rtl/fe_tx_mlt3.sv
module fe_tx_mlt3
  import fe_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_in,
  output logic [1:0] lvl
);
  logic up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= LV_ZERO;
      up  <= 1'b1;
    end else if (bit_in) begin
      if (lvl == LV_ZERO) begin
        lvl <= up ? LV_POS : LV_NEG;
      end else begin
        lvl <= LV_ZERO;
        up  <= (lvl == LV_NEG);
      end
    end
  end
endmodule

// File: rtl/fe_tx_encoder.sv
module fe_tx_encoder #(
  parameter int NIB_W  = 4,
  parameter int CG_W   = 5,
  parameter int DIV    = 5,
  parameter int LFSR_W = 11,
  parameter int TAP    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NIB_W-1:0] in_data,
  output logic             in_ready,
  output logic [1:0]       line_lvl
);
  logic            slot;
  logic [CG_W-1:0] cg;
  logic            scr_bit;

  fe_tx_framer #(.DIV(DIV), .NIB_W(NIB_W), .CG_W(CG_W)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .slot     (slot),
    .cg       (cg)
  );

  fe_tx_scrambler #(.CG_W(CG_W), .LFSR_W(LFSR_W), .TAP(TAP)) u_scr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (slot),
    .cg      (cg),
    .scr_bit (scr_bit)
  );

  fe_tx_mlt3 u_mlt3 (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (scr_bit),
    .lvl    (line_lvl)
  );
endmodule

// File: rtl/fe_tx_encoder_chk.sv
module fe_tx_encoder_chk #(
  parameter int DIV = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic [1:0] line_lvl
);
  logic [1:0] last_nz;
  int unsigned gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_nz <= 2'b11;
      gap     <= 0;
    end else begin
      if (line_lvl != 2'b00) last_nz <= line_lvl;
      gap <= in_ready ? 0 : gap + 1;
    end
  end

  // R8
  legal_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_lvl != 2'b10);

  // R8
  step_via_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_lvl) != 2'b00 && line_lvl != $past(line_lvl)) |-> line_lvl == 2'b00);

  // R8
  alternate_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_lvl) == 2'b00 && line_lvl != 2'b00) |-> line_lvl != last_nz);

  // R1
  ready_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (gap == DIV - 1 || gap == 2 * DIV - 1));

  // R6
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
endmodule

bind fe_tx_encoder fe_tx_encoder_chk #(.DIV(DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .line_lvl (line_lvl)
);

// File: tb/sim_fe_tx_encoder.sv
module sim_fe_tx_encoder;
  localparam int CLK_PERIOD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_data = 4'h0;
  logic       in_ready;
  logic [1:0] line_lvl;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fe_tx_encoder u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .line_lvl (line_lvl)
  );

  int         checks = 0;
  int         fails = 0;
  logic [4:0] exp_q[$];
  logic [3:0] fq[$];
  int         frames_sent = 0;
  int         frames_seen = 0;
  bit         in_frame = 0;
  int         zeros = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] cg_of(input logic [3:0] n);
    logic [4:0] t[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                          5'b01010, 5'b01011, 5'b01110, 5'b01111,
                          5'b10010, 5'b10011, 5'b10110, 5'b10111,
                          5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  // driver: pushes expected code-groups, then offers the nibbles of fq
  task automatic send_frame(input bit chk_gap);
    int gap;
    for (int i = 2; i < fq.size(); i++) exp_q.push_back(cg_of(fq[i]));
    exp_q.push_back(5'b01101);
    exp_q.push_back(5'b00111);
    frames_sent++;
    for (int i = 0; i < fq.size(); i++) begin
      in_valid = 1'b1;
      in_data  = fq[i];
      gap = 0;
      while (!in_ready) begin
        @(negedge clk);
        gap++;
      end
      if (i == 0 && chk_gap) chk(gap == 9, "R6", "ready gap over R slot", gap, 9);
      if (i > 0) chk(gap == 4, "R1", "ready gap inside frame", gap, 4);
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: decode levels to bits, descramble, frame and compare
  initial begin : monitor
    logic [10:0] bl;
    logic [1:0]  prev, nl;
    logic [9:0]  win;
    logic [4:0]  grp, e;
    bit          up, key, sbit, pbit;
    int          bc;
    bl = 11'h7FF; prev = 2'b00; up = 1'b1; win = 10'h3FF; bc = 0; grp = '0;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      key  = bl[10] ^ bl[8];
      bl   = {bl[9:0], key};
      sbit = (line_lvl != prev);
      if (sbit) begin
        if (prev == 2'b00) nl = up ? 2'b01 : 2'b11;
        else nl = 2'b00;
        chk(line_lvl == nl, "R8", "level step", line_lvl, nl);
        if (prev == 2'b01) up = 1'b0;
        if (prev == 2'b11) up = 1'b1;
      end
      prev = line_lvl;
      pbit = sbit ^ key;  // R7 descramble
      win  = {win[8:0], pbit};
      if (!in_frame) begin
        if (!pbit) zeros++;
        if (win == 10'b1100010001) begin
          chk(zeros == 6, "R2", "zero bits in idle plus J,K", zeros, 6);
          frames_seen++;
          in_frame = 1;
          bc = 0;
        end
      end else begin
        grp = {grp[3:0], pbit};
        bc++;
        if (bc == 5) begin
          bc = 0;
          if (exp_q.size() == 0) begin
            chk(0, "R5", "unexpected code-group", grp, 0);
          end else begin
            e = exp_q.pop_front();
            chk(grp == e, "R4/R5", "code-group", grp, e);
            if (e == 5'b00111) begin
              in_frame = 0;
              zeros = 0;
              win = 10'h3FF;
            end
          end
        end
      end
    end
  end

  initial begin
    fork
      begin : seq
        repeat (4) @(negedge clk);
        chk(line_lvl == 2'b00, "R9", "level in reset", line_lvl, 0);
        chk(in_ready == 1'b0, "R9", "ready in reset", in_ready, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(line_lvl != 2'b10, "R8", "illegal level", line_lvl, 0);
        repeat (40) @(negedge clk);
        chk(frames_seen == 0 && !in_frame, "R2", "idle before frames", frames_seen, 0);
        // ordinary preamble-led frame
        fq = {4'h5, 4'h5, 4'h5, 4'h5, 4'h5, 4'hD, 4'h1, 4'h2, 4'hE};
        send_frame(0);
        repeat (23) @(negedge clk);
        // R3 odd first byte, R4 every data nibble
        fq = {4'h3, 4'hA};
        for (int v = 0; v < 16; v++) fq.push_back(4'(v));
        send_frame(0);
        repeat (12) @(negedge clk);
        // R5 shortest frame, then back-to-back (R6)
        fq = {4'h0, 4'hF};
        send_frame(0);
        fq = {4'h5, 4'h5, 4'h7, 4'h0, 4'hC};
        send_frame(1);
        repeat (60) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "groups left unsent", exp_q.size(), 0);
        chk(frames_seen == frames_sent, "R3", "frames with J,K", frames_seen, frames_sent);
        chk(!in_frame && zeros == 0, "R2", "idle after frames", zeros, 0);
      end
      begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R1 watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule